// File: doc/BRIEF.md
# Scan Trigger Generator with Encoder Capture

This block issues trigger pulses for continuous motion scans and, on every trigger, stores a snapshot of the scan axes. It decodes several quadrature encoders and counts rising edges on a detector input. Each accepted trigger freezes every encoder count and the detector count into one record. The record goes into an on-chip circular buffer. A host drains that buffer through a simple request/response read port, and it can do so while the scan is still running.

Six trigger sources are available. There is a plain timer and three position modes: ascending, descending and back-and-forth. A fifth mode waits for a position and then runs on the timer. The sixth follows an external pulse input. Configuration is sampled when a scan starts. Start, stop and abort commands drive a four-state sequencer. When a trigger finds the buffer full, the scan halts rather than overwrite data the host has not yet read.

Top module: `scan_trig_gen`

## Requirements
- R1: While `rst` is high and after it is released, `trig_out` is 0, `scan_state` is 0 (idle), `buf_level` is 0, `overflow` is 0 and `trig_issued` is 0.
- R2: `cfg_mode` 0 (timer). `start` is sampled at clock edge E. The first trigger pulse rises at edge E+`cfg_start`+1. Later rises follow every `cfg_step` cycles. Each pulse stays high for `cfg_width` cycles, and a width of 0 counts as 1.
- R3: When `cfg_count` is non-zero, the scan stops after `cfg_count` triggers. `scan_state` then reads 3 (done), `trig_issued` equals `cfg_count`, and no further pulse is issued. The done state holds until `start` or `abort`. State codes: 0 idle, 1 armed (before the first trigger), 2 running, 3 done.
- R4: `cfg_mode` 1 fires when the selected encoder count is greater than or equal to the target. `cfg_mode` 2 fires when it is less than or equal to the target. The first target is `cfg_start`. After each trigger the target moves by `cfg_step`: up in mode 1, down in mode 2. All comparisons are signed.
- R5: `cfg_mode` 3 (back-and-forth) begins in the ascending direction. After `cfg_span` triggers in one direction, the direction reverses. At each trigger the next target moves one step in the direction that follows that trigger.
- R6: `cfg_mode` 4 issues no trigger until the selected encoder count reaches `cfg_start`. It then fires at once and afterwards every `cfg_step` cycles.
- R7: `cfg_mode` 5 issues one trigger for each rising edge of `ext_trig`, after a two-flop synchronizer. Holding the input high yields only one trigger.
- R8: A record is read with a one-cycle `rd_req` while the buffer is not empty. In the next cycle `rd_valid` is 1. `rd_data[31:0]` holds the detector count, and encoder i is at `rd_data[32*(i+1) +: 32]`. Records come out oldest first, and reads are allowed while a scan runs.
- R9: Each encoder is decoded in x4 mode. The (A,B) sequence 00→01→11→10→00 counts up by one per step, and the reverse sequence counts down.
- R10: A trigger that finds the buffer full (`buf_level` = DEPTH) sends no pulse and writes no record. It sets the sticky `overflow` flag and moves the scan to done. The stored records are kept.
- R11: `stop` moves an armed or running scan to done. `abort` returns to idle and empties the buffer. `start`, accepted only in idle or done, clears `overflow` and `trig_issued`.
- R12: `cfg_sel`, latched at start, picks the encoder used for position comparison. Motion on any other encoder never causes a trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a scan (idle or done only) |
| stop | input | 1 | End the scan gracefully |
| abort | input | 1 | Return to idle and flush the buffer |
| cfg_mode | input | 3 | Trigger source, codes 0..5 |
| cfg_start | input | 32 | Start delay (timer) or first target position (signed) |
| cfg_step | input | 32 | Timer period or position step |
| cfg_span | input | 16 | Triggers per direction in back-and-forth mode (0 = no reversal) |
| cfg_count | input | 16 | Trigger limit (0 = unlimited) |
| cfg_width | input | 8 | Pulse width in cycles |
| cfg_sel | input | 3 | Encoder used for comparison |
| enc_a | input | NUM_ENC | Quadrature A inputs |
| enc_b | input | NUM_ENC | Quadrature B inputs |
| cnt_in | input | 1 | Detector pulse input |
| ext_trig | input | 1 | External trigger input |
| rd_req | input | 1 | Read one record |
| trig_out | output | 1 | Trigger pulse |
| rd_valid | output | 1 | Record on rd_data is valid |
| rd_data | output | 32*(NUM_ENC+1) | Record contents |
| buf_level | output | $clog2(DEPTH)+1 | Records held |
| scan_state | output | 2 | Sequencer state |
| trig_issued | output | 16 | Triggers issued this scan |
| overflow | output | 1 | Sticky buffer-full flag |

## Verification
The bench targets timer alignment. A design off by one in the start delay or the reload value would move the first edge or the spacing, and the bench checks that edge-by-edge. The turn-around of the back-and-forth mode is checked through the exact captured positions. A wrong target update at the reversal would repeat a position or skip one. The buffer-full case checks that the seventeenth trigger is blocked rather than stored. A design that wrapped the write pointer would corrupt the record count or the oldest record. A held external input and motion on a non-selected encoder must both leave the trigger count untouched.

// File: rtl/stg_pkg.sv
package stg_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_RUN   = 2'd2,
    ST_DONE  = 2'd3
  } scan_st_t;

  localparam logic [2:0] M_TIME = 3'd0;
  localparam logic [2:0] M_UP   = 3'd1;
  localparam logic [2:0] M_DN   = 3'd2;
  localparam logic [2:0] M_ZIG  = 3'd3;
  localparam logic [2:0] M_TPOS = 3'd4;
  localparam logic [2:0] M_EXT  = 3'd5;
endpackage

// File: rtl/stg_quad.sv
module stg_quad #(
  parameter int W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                a,
  input  logic                b,
  output logic signed [W-1:0] count
);
  logic [1:0] sa, sb;
  logic [1:0] prev;
  logic [1:0] cur;
  logic       up, dn;

  assign cur = {sa[1], sb[1]};

  always_comb begin
    up = 1'b0;
    dn = 1'b0;
    case ({prev, cur})
      4'b0001, 4'b0111, 4'b1110, 4'b1000: up = 1'b1;
      4'b0100, 4'b1101, 4'b1011, 4'b0010: dn = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sa    <= '0;
      sb    <= '0;
      prev  <= '0;
      count <= '0;
    end else begin
      sa   <= {sa[0], a};
      sb   <= {sb[0], b};
      prev <= cur;
      if (up)      count <= count + 1'b1;
      else if (dn) count <= count - 1'b1;
    end
  end

  // R9
  quad_step_chk: assert property (@(posedge clk) disable iff (rst)
    (count == $past(count)) || (count == $past(count) + 1) || (count == $past(count) - 1));
endmodule

// File: rtl/stg_rec_buf.sv
module stg_rec_buf #(
  parameter int DW    = 192,
  parameter int DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_req,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic [$clog2(DEPTH):0] level,
  output logic          full
);
  localparam int AW = $clog2(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          do_wr, do_rd;

  assign full  = (level == DEPTH[AW:0]);
  assign do_wr = wr_en && !full;
  assign do_rd = rd_req && (level != '0);

  always_ff @(posedge clk) begin
    if (do_wr) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (do_rd) rd_data <= mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wptr     <= '0;
      rptr     <= '0;
      level    <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= do_rd;
      if (do_wr) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (do_rd) rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      case ({do_wr, do_rd})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: ;
      endcase
    end
  end

  // R10
  level_bound_chk: assert property (@(posedge clk) disable iff (rst)
    level <= DEPTH[AW:0]);
  // R8
  rd_after_req_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(rd_req));
endmodule

// File: rtl/stg_engine.sv
module stg_engine
  import stg_pkg::*;
#(
  parameter int PW = 32,
  parameter int CW = 16,
  parameter int WW = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic                 stop,
  input  logic                 abort,
  input  logic [2:0]           cfg_mode,
  input  logic signed [PW-1:0] cfg_start,
  input  logic [PW-1:0]        cfg_step,
  input  logic [15:0]          cfg_span,
  input  logic [CW-1:0]        cfg_count,
  input  logic [WW-1:0]        cfg_width,
  input  logic signed [PW-1:0] pos,
  input  logic                 ext_rise,
  input  logic                 buf_full,
  output logic                 fire,
  output logic                 start_go,
  output logic                 trig_out,
  output scan_st_t             st,
  output logic [CW-1:0]        issued,
  output logic                 overflow
);
  logic [2:0]           mode_q;
  logic signed [PW-1:0] start_q, tgt_q;
  logic [PW-1:0]        step_q, tmr_q, per_m1;
  logic [15:0]          span_q, pass_q;
  logic [CW-1:0]        count_q;
  logic [WW-1:0]        width_q, wcnt;
  logic                 dir_q, gate_q;
  logic                 active, hit, blocked, flip, new_dir, last;

  assign active   = (st == ST_ARMED) || (st == ST_RUN);
  assign start_go = start && ((st == ST_IDLE) || (st == ST_DONE)) && !abort;
  assign per_m1   = (step_q == '0) ? '0 : step_q - 1'b1;

  always_comb begin
    case (mode_q)
      M_TIME, M_TPOS: hit = gate_q ? (tmr_q == '0) : (pos >= start_q);
      M_UP, M_DN, M_ZIG: hit = dir_q ? (pos >= tgt_q) : (pos <= tgt_q);
      M_EXT:   hit = ext_rise;
      default: hit = 1'b0;
    endcase
  end

  assign fire    = active && hit && !buf_full && !stop && !abort;
  assign blocked = active && hit && buf_full && !stop && !abort;
  assign flip    = (mode_q == M_ZIG) && (pass_q + 16'd1 == span_q);
  assign new_dir = flip ? !dir_q : dir_q;
  assign last    = (count_q != '0) && (issued + 1'b1 == count_q);
  assign trig_out = (wcnt != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      mode_q   <= M_TIME;
      start_q  <= '0;
      tgt_q    <= '0;
      step_q   <= '0;
      tmr_q    <= '0;
      span_q   <= '0;
      pass_q   <= '0;
      count_q  <= '0;
      width_q  <= '0;
      dir_q    <= 1'b1;
      gate_q   <= 1'b0;
      issued   <= '0;
      overflow <= 1'b0;
      wcnt     <= '0;
    end else begin
      if (fire)             wcnt <= (width_q == '0) ? WW'(1) : width_q;
      else if (wcnt != '0)  wcnt <= wcnt - 1'b1;

      if (abort) begin
        st <= ST_IDLE;
      end else if (start_go) begin
        st       <= ST_ARMED;
        mode_q   <= cfg_mode;
        start_q  <= cfg_start;
        tgt_q    <= cfg_start;
        step_q   <= cfg_step;
        tmr_q    <= cfg_start;
        span_q   <= cfg_span;
        pass_q   <= '0;
        count_q  <= cfg_count;
        width_q  <= cfg_width;
        dir_q    <= (cfg_mode != M_DN);
        gate_q   <= (cfg_mode == M_TIME);
        issued   <= '0;
        overflow <= 1'b0;
      end else if (active && stop) begin
        st <= ST_DONE;
      end else if (blocked) begin
        overflow <= 1'b1;
        st       <= ST_DONE;
      end else if (fire) begin
        issued <= issued + 1'b1;
        st     <= last ? ST_DONE : ST_RUN;
        gate_q <= 1'b1;
        tmr_q  <= per_m1;
        dir_q  <= new_dir;
        pass_q <= flip ? '0 : pass_q + 16'd1;
        tgt_q  <= new_dir ? tgt_q + $signed(step_q) : tgt_q - $signed(step_q);
      end else if (active && gate_q && tmr_q != '0) begin
        tmr_q <= tmr_q - 1'b1;
      end
    end
  end

  // R3
  pulse_needs_scan_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(trig_out) |-> ($past(st) == ST_ARMED || $past(st) == ST_RUN));
  // R3
  done_holds_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_DONE && !start && !abort) |=> st == ST_DONE);
  // R10
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (overflow && !start_go) |=> overflow);
  // R11
  abort_idle_chk: assert property (@(posedge clk) disable iff (rst)
    abort |=> st == ST_IDLE);
endmodule

// File: rtl/scan_trig_gen.sv
module scan_trig_gen
  import stg_pkg::*;
#(
  parameter int NUM_ENC = 5,
  parameter int DEPTH   = 16,
  parameter int PW      = 32,
  parameter int CW      = 16,
  parameter int WW      = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       start,
  input  logic                       stop,
  input  logic                       abort,
  input  logic [2:0]                 cfg_mode,
  input  logic [PW-1:0]              cfg_start,
  input  logic [PW-1:0]              cfg_step,
  input  logic [15:0]                cfg_span,
  input  logic [CW-1:0]              cfg_count,
  input  logic [WW-1:0]              cfg_width,
  input  logic [2:0]                 cfg_sel,
  input  logic [NUM_ENC-1:0]         enc_a,
  input  logic [NUM_ENC-1:0]         enc_b,
  input  logic                       cnt_in,
  input  logic                       ext_trig,
  input  logic                       rd_req,
  output logic                       trig_out,
  output logic                       rd_valid,
  output logic [PW*(NUM_ENC+1)-1:0]  rd_data,
  output logic [$clog2(DEPTH):0]     buf_level,
  output logic [1:0]                 scan_state,
  output logic [CW-1:0]              trig_issued,
  output logic                       overflow
);
  localparam int RW = PW * (NUM_ENC + 1);

  logic signed [PW-1:0] enc_cnt [NUM_ENC];
  logic [RW-1:0]        rec;
  logic [2:0]           ext_s, cnt_s;
  logic [PW-1:0]        det_cnt;
  logic [2:0]           sel_q;
  logic signed [PW-1:0] pos;
  logic                 fire, start_go, buf_full;
  scan_st_t             st;

  for (genvar i = 0; i < NUM_ENC; i++) begin : g_enc
    stg_quad #(.W(PW)) u_quad (
      .clk   (clk),
      .rst   (rst),
      .a     (enc_a[i]),
      .b     (enc_b[i]),
      .count (enc_cnt[i])
    );
    assign rec[PW*(i+1) +: PW] = enc_cnt[i];
  end
  assign rec[PW-1:0] = det_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      ext_s   <= '0;
      cnt_s   <= '0;
      det_cnt <= '0;
      sel_q   <= '0;
    end else begin
      ext_s <= {ext_s[1:0], ext_trig};
      cnt_s <= {cnt_s[1:0], cnt_in};
      if (cnt_s[1] && !cnt_s[2]) det_cnt <= det_cnt + 1'b1;
      if (start_go) sel_q <= (cfg_sel < 3'(NUM_ENC)) ? cfg_sel : '0;
    end
  end

  assign pos = enc_cnt[sel_q];

  stg_engine #(.PW(PW), .CW(CW), .WW(WW)) u_engine (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .stop      (stop),
    .abort     (abort),
    .cfg_mode  (cfg_mode),
    .cfg_start (cfg_start),
    .cfg_step  (cfg_step),
    .cfg_span  (cfg_span),
    .cfg_count (cfg_count),
    .cfg_width (cfg_width),
    .pos       (pos),
    .ext_rise  (ext_s[1] && !ext_s[2]),
    .buf_full  (buf_full),
    .fire      (fire),
    .start_go  (start_go),
    .trig_out  (trig_out),
    .st        (st),
    .issued    (trig_issued),
    .overflow  (overflow)
  );

  stg_rec_buf #(.DW(RW), .DEPTH(DEPTH)) u_buf (
    .clk      (clk),
    .rst      (rst),
    .flush    (abort),
    .wr_en    (fire),
    .wr_data  (rec),
    .rd_req   (rd_req),
    .rd_valid (rd_valid),
    .rd_data  (rd_data),
    .level    (buf_level),
    .full     (buf_full)
  );

  assign scan_state = st;
endmodule

// File: tb/scan_trig_gen_bench.sv
module scan_trig_gen_bench;
  localparam int NE = 5;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 0, stop = 0, abort = 0, cnt_in = 0, ext_trig = 0, rd_req = 0;
  logic [2:0]  cfg_mode = 0, cfg_sel = 0;
  logic [31:0] cfg_start = 0, cfg_step = 0;
  logic [15:0] cfg_span = 0, cfg_count = 0;
  logic [7:0]  cfg_width = 0;
  logic [NE-1:0] enc_a = '0, enc_b = '0;
  logic        trig_out, rd_valid, overflow;
  logic [32*(NE+1)-1:0] rd_data;
  logic [4:0]  buf_level;
  logic [1:0]  scan_state;
  logic [15:0] trig_issued;

  int checks = 0, failures = 0, cycles = 0;
  int ph [NE];
  int ep [NE];
  int det_total = 0;

  always #2.5 clk = ~clk;

  scan_trig_gen #(.NUM_ENC(NE), .DEPTH(DEPTH)) u_scan_trig_gen (
    .clk(clk), .rst(rst), .start(start), .stop(stop), .abort(abort),
    .cfg_mode(cfg_mode), .cfg_start(cfg_start), .cfg_step(cfg_step),
    .cfg_span(cfg_span), .cfg_count(cfg_count), .cfg_width(cfg_width),
    .cfg_sel(cfg_sel), .enc_a(enc_a), .enc_b(enc_b), .cnt_in(cnt_in),
    .ext_trig(ext_trig), .rd_req(rd_req), .trig_out(trig_out),
    .rd_valid(rd_valid), .rd_data(rd_data), .buf_level(buf_level),
    .scan_state(scan_state), .trig_issued(trig_issued), .overflow(overflow)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 100000) begin
      failures = failures + 1;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_abort();
    @(negedge clk) abort = 1;
    @(negedge clk) abort = 0;
  endtask

  task automatic do_start(input int m, input int s, input int p, input int w,
                          input int c, input int sel, input int span);
    cfg_mode = m[2:0]; cfg_start = s; cfg_step = p; cfg_width = w[7:0];
    cfg_count = c[15:0]; cfg_sel = sel[2:0]; cfg_span = span[15:0];
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
  endtask

  task automatic read_rec(output logic [32*(NE+1)-1:0] d, output bit v);
    @(negedge clk) rd_req = 1;
    @(negedge clk) rd_req = 0;
    v = rd_valid;
    d = rd_data;
  endtask

  task automatic move(input int i, input int d);
    ph[i] = (ph[i] + d) & 3;
    ep[i] = ep[i] + d;
    enc_a[i] = (ph[i] == 2) || (ph[i] == 3);
    enc_b[i] = (ph[i] == 1) || (ph[i] == 2);
    waitc(5);
  endtask

  task automatic move_to(input int i, input int t);
    while (ep[i] < t) move(i, 1);
    while (ep[i] > t) move(i, -1);
  endtask

  task automatic det_pulse();
    @(negedge clk) cnt_in = 1;
    waitc(3);
    cnt_in = 0;
    waitc(3);
    det_total++;
  endtask

  task automatic ext_pulse(input int hold);
    @(negedge clk) ext_trig = 1;
    waitc(hold);
    ext_trig = 0;
    waitc(6);
  endtask

  function automatic longint fld(input logic [32*(NE+1)-1:0] d, input int k);
    return longint'($signed(d[32*k +: 32]));
  endfunction

  // timer vectors: {start delay, period, width, count}
  localparam logic [31:0] TV [4] = '{
    {8'd0, 8'd3, 8'd1, 8'd4},
    {8'd5, 8'd4, 8'd2, 8'd3},
    {8'd2, 8'd6, 8'd0, 8'd2},
    {8'd1, 8'd2, 8'd1, 8'd5}
  };

  initial begin
    logic [32*(NE+1)-1:0] d;
    bit v;
    for (int i = 0; i < NE; i++) begin ph[i] = 0; ep[i] = 0; end

    // R1 reset state
    waitc(3);
    chk(trig_out == 0 && scan_state == 0, "R1 trig/state in reset", scan_state, 0);
    @(negedge clk) rst = 0;
    waitc(2);
    chk(buf_level == 0 && overflow == 0 && trig_issued == 0, "R1 level/flag/count", buf_level, 0);
    chk(scan_state == 0 && trig_out == 0, "R1 idle after reset", scan_state, 0);

    // R2 / R3 timer vectors
    for (int k = 0; k < 4; k++) begin
      int st_d, per, w, cnt, len, first, last, rises, high, badgap, eh;
      bit prv;
      st_d = TV[k][31:24]; per = TV[k][23:16]; w = TV[k][15:8]; cnt = TV[k][7:0];
      do_abort();
      do_start(0, st_d, per, w, cnt, 0, 0);
      len = st_d + per * cnt + 12;
      first = -1; last = -1; rises = 0; high = 0; badgap = 0; prv = 0;
      for (int c = 1; c <= len; c++) begin
        @(negedge clk);
        if (trig_out && !prv) begin
          rises++;
          if (first < 0) first = c;
          else if (c - last != per) badgap++;
          last = c;
        end
        if (trig_out) high++;
        prv = trig_out;
      end
      eh = cnt * ((w == 0) ? 1 : w);
      chk(first == st_d + 1, "R2 first pulse cycle", first, st_d + 1);
      chk(badgap == 0, "R2 pulse spacing", badgap, 0);
      chk(high == eh, "R2 pulse width total", high, eh);
      chk(rises == cnt, "R3 pulse count", rises, cnt);
      chk(scan_state == 3 && trig_issued == cnt, "R3 done and issued", trig_issued, cnt);
      chk(buf_level == cnt, "R8 records stored", buf_level, cnt);
    end

    // R12 / R4 ascending on encoder 2
    do_abort();
    do_start(1, 3, 4, 1, 3, 2, 0);
    move_to(0, 5);
    waitc(4);
    chk(trig_issued == 0, "R12 other encoder ignored", trig_issued, 0);
    chk(scan_state == 1, "R3 armed before first trigger", scan_state, 1);
    move_to(2, 13);
    waitc(6);
    chk(trig_issued == 3 && scan_state == 3, "R4 ascending count", trig_issued, 3);
    for (int r = 0; r < 3; r++) begin
      read_rec(d, v);
      chk(v && fld(d, 3) == 3 + 4 * r, "R4 ascending position", fld(d, 3), 3 + 4 * r);
      chk(fld(d, 1) == 5, "R9 encoder 0 decoded", fld(d, 1), 5);
    end

    // R4 descending on encoder 1
    do_abort();
    do_start(2, -2, 3, 1, 2, 1, 0);
    move_to(1, -6);
    waitc(6);
    chk(trig_issued == 2 && scan_state == 3, "R4 descending count", trig_issued, 2);
    for (int r = 0; r < 2; r++) begin
      read_rec(d, v);
      chk(v && fld(d, 2) == -2 - 3 * r, "R4 descending position", fld(d, 2), -2 - 3 * r);
    end

    // R5 back-and-forth on encoder 3
    do_abort();
    do_start(3, 10, 5, 1, 6, 3, 3);
    move_to(3, 22);
    chk(trig_issued == 3, "R5 forward pass count", trig_issued, 3);
    move_to(3, 3);
    waitc(6);
    chk(trig_issued == 6 && scan_state == 3, "R5 total count", trig_issued, 6);
    begin
      int exp_p [6] = '{10, 15, 20, 15, 10, 5};
      for (int r = 0; r < 6; r++) begin
        read_rec(d, v);
        chk(v && fld(d, 4) == exp_p[r], "R5 captured position", fld(d, 4), exp_p[r]);
      end
    end

    // R6 position-gated timer on encoder 4
    do_abort();
    do_start(4, 8, 4, 1, 3, 4, 0);
    move_to(4, 7);
    waitc(10);
    chk(trig_issued == 0, "R6 no trigger before position", trig_issued, 0);
    move_to(4, 8);
    waitc(15);
    chk(trig_issued == 3 && scan_state == 3, "R6 triggers after position", trig_issued, 3);
    read_rec(d, v);
    chk(v && fld(d, 5) == 8, "R6 first capture at position", fld(d, 5), 8);

    // R7 / R8 external trigger with detector counts, read during scan
    do_abort();
    do_start(5, 0, 0, 1, 0, 0, 0);
    det_pulse(); det_pulse();
    ext_pulse(10);
    chk(trig_issued == 1, "R7 held input gives one trigger", trig_issued, 1);
    det_pulse();
    ext_pulse(2);
    chk(trig_issued == 2, "R7 second edge", trig_issued, 2);
    read_rec(d, v);
    chk(v && fld(d, 0) == det_total - 1, "R8 counter field oldest", fld(d, 0), det_total - 1);
    chk(scan_state == 2, "R8 read while running", scan_state, 2);
    read_rec(d, v);
    chk(v && fld(d, 0) == det_total, "R8 counter field second", fld(d, 0), det_total);
    read_rec(d, v);
    chk(v == 0, "R8 no valid on empty", v, 0);

    // R10 overflow
    do_abort();
    do_start(0, 0, 2, 1, 0, 0, 0);
    waitc(60);
    chk(overflow == 1 && scan_state == 3, "R10 overflow stops scan", overflow, 1);
    chk(trig_issued == DEPTH && buf_level == DEPTH, "R10 no record lost", trig_issued, DEPTH);
    read_rec(d, v);
    chk(v && fld(d, 3) == ep[2] && buf_level == DEPTH - 1, "R10 records kept", buf_level, DEPTH - 1);
    do_start(0, 50, 50, 1, 0, 0, 0);
    waitc(2);
    chk(overflow == 0 && trig_issued == 0, "R11 start clears flag", overflow, 0);

    // R11 stop and abort
    do_abort();
    do_start(0, 0, 50, 1, 0, 0, 0);
    waitc(5);
    chk(trig_issued == 1, "R11 first trigger", trig_issued, 1);
    @(negedge clk) stop = 1;
    @(negedge clk) stop = 0;
    chk(scan_state == 3, "R11 stop gives done", scan_state, 3);
    waitc(100);
    chk(trig_issued == 1, "R11 no trigger after stop", trig_issued, 1);
    do_abort();
    chk(scan_state == 0 && buf_level == 0, "R11 abort flushes", buf_level, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule